// File: doc/BRIEF.md
# Half-Duplex Converter Bus Interface

This block is the digital side of a paired receive ADC and transmit DAC that share one parallel data bus. Two enable inputs choose between three modes. In transmit mode the block takes a 7-bit two's-complement word from the bus and passes it to the DAC code. In receive mode it takes a 5-bit two's-complement conversion result and drives it onto the lower five bus lines. In shutdown both paths are idle and the bus is released.

Both data paths have two stages. The first stage samples on the falling clock edge. The second stage updates on the rising edge that follows, so data always arrives half a cycle after it is sampled.

A mode controller runs four states:
- **OFF**: shutdown.
- **WAKE**: counting out the wake-up delay.
- **TX**: transmit, ready.
- **RX**: receive, ready.

The transitions are:
- **wake-request**: OFF to WAKE when either single enable appears.
- **wake-done**: WAKE to TX or RX when the delay counter expires.
- **abort**: any state to OFF when the enables select shutdown.
- **swap**: TX to RX, or RX to TX, directly, without a new delay.

The ready output is high in TX and RX.

Top module: `hdx_conv_if`

## Requirements
- R1: The enable pair {rx_en, tx_en} is decoded as follows: 00 and 11 select shutdown, 01 selects transmit and 10 selects receive. One rising edge after shutdown is selected, ready is 0.
- R2: The reset rst_n is synchronous and active low. After reset, ready, dac_code, bus_out and bus_oe are all 0.
- R3: Ready goes to 1 exactly WAKE_CYC rising edges after the first rising edge that samples a transmit or receive selection in OFF. If shutdown is selected during the wait, the count starts again from the next request.
- R4: A direct switch between transmit and receive keeps ready at 1 and does not restart the wake-up count.
- R5: bus_in[6:0] is sampled on the falling edge while transmit is selected, with bit 6 as the MSB. The value appears on dac_code at the next rising edge when the state is TX and transmit is still selected. A change to bus_in after that falling edge does not affect that update.
- R6: At every rising edge where the TX-and-transmit condition is false, dac_code is set to 0000000. This includes wake-up, receive and shutdown.
- R7: adc_code[4:0] is sampled on the falling edge while receive is selected, with bit 4 as the MSB. It appears on bus_out at the next rising edge in state RX. Otherwise bus_out is 0.
- R8: bus_oe is 1 only in state RX while receive is currently selected. It drops in the same cycle that the enables leave receive.
- R9: Codes pass through unchanged, including the extremes: 0111111 and 1000000 for the DAC, 01111 and 10000 for the ADC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; both edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| bus_in | input | 7 | Shared bus as seen at the pins (DAC data in transmit) |
| adc_code | input | 5 | Comparator-array result, two's complement |
| dac_code | output | 7 | Code to the DAC switches |
| bus_out | output | 5 | Receive data for bus lines 4..0 |
| bus_oe | output | 1 | Output enable for bus lines 4..0 |
| ready | output | 1 | Wake-up complete |

## Verification
Inputs change 2 ns after a rising edge, and outputs are compared 5 ns after a rising edge, which keeps both clear of the falling edge at 10 ns. The due times are as follows:
- A DAC word or ADC sample driven in cycle c is due at cycle c+1.
- bus_oe is due in the same cycle as an enable change.
- ready is due WAKE_CYC+1 cycles after the enable is driven.

Each stimulus task queues its result with the absolute cycle number at which it is due. The monitor compares only entries whose cycle has arrived. A bus change placed just after the falling edge shows that the capture happens at the falling edge and the transfer at the rising edge.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    typedef enum logic [1:0] {
        REQ_OFF = 2'd0,
        REQ_TX  = 2'd1,
        REQ_RX  = 2'd2
    } req_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAKE = 2'd1,
        ST_TX   = 2'd2,
        ST_RX   = 2'd3
    } st_t;

    function automatic req_t decode_req(input logic rx, input logic tx);
        if (rx && !tx)      return REQ_RX;
        else if (tx && !rx) return REQ_TX;
        else                return REQ_OFF;
    endfunction

endpackage

// File: rtl/hdx_mode_ctl.sv
module hdx_mode_ctl
    import hdx_pkg::*;
#(
    parameter int WAKE_CYC = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic tx_en,
    output logic tx_sel,
    output logic rx_sel,
    output logic tx_load,
    output logic rx_load,
    output logic ready
);
    localparam int CNT_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYC - 1);

    req_t req;
    st_t state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    assign req = decode_req(rx_en, tx_en);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_OFF: begin
                if (req != REQ_OFF) begin
                    state_nxt = ST_WAKE;
                    cnt_nxt   = '0;
                end
            end
            ST_WAKE: begin
                if (req == REQ_OFF)       state_nxt = ST_OFF;
                else if (cnt == LAST)     state_nxt = (req == REQ_TX) ? ST_TX : ST_RX;
                else                      cnt_nxt   = cnt + CNT_W'(1);
            end
            ST_TX: begin
                if (req == REQ_OFF)       state_nxt = ST_OFF;
                else if (req == REQ_RX)   state_nxt = ST_RX;
            end
            ST_RX: begin
                if (req == REQ_OFF)       state_nxt = ST_OFF;
                else if (req == REQ_TX)   state_nxt = ST_TX;
            end
        endcase
    end

    always_comb begin
        tx_sel  = (req == REQ_TX);
        rx_sel  = (req == REQ_RX);
        ready   = (state == ST_TX) || (state == ST_RX);
        tx_load = (state == ST_TX) && (req == REQ_TX);
        rx_load = (state == ST_RX) && (req == REQ_RX);
    end

    p_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req == REQ_OFF) |=> !ready);
    p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(state) == ST_WAKE && $past(cnt) == LAST));
    p_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE) |-> (cnt <= LAST));
    p_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req != REQ_OFF) |=> ready);

endmodule

// File: rtl/hdx_dac_path.sv
module hdx_dac_path #(
    parameter int DAC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             load,
    input  logic [DAC_W-1:0] din,
    output logic [DAC_W-1:0] code
);
    logic [DAC_W-1:0] master;

    always_ff @(negedge clk) begin
        if (!rst_n)      master <= '0;
        else if (cap_en) master <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    code <= '0;
        else if (load) code <= master;
        else           code <= '0;
    end

    p_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (code == $past(master)));
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (code == '0));

endmodule

// File: rtl/hdx_adc_path.sv
module hdx_adc_path #(
    parameter int ADC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic             load,
    input  logic [ADC_W-1:0] sample,
    output logic [ADC_W-1:0] dout
);
    logic [ADC_W-1:0] held;

    always_ff @(negedge clk) begin
        if (!rst_n)       held <= '0;
        else if (samp_en) held <= sample;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= held;
        else           dout <= '0;
    end

    p_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dout == $past(held)));
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (dout == '0));

endmodule

// File: rtl/hdx_conv_if.sv
module hdx_conv_if #(
    parameter int DAC_W    = 7,
    parameter int ADC_W    = 5,
    parameter int WAKE_CYC = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic [DAC_W-1:0] bus_in,
    input  logic [ADC_W-1:0] adc_code,
    output logic [DAC_W-1:0] dac_code,
    output logic [ADC_W-1:0] bus_out,
    output logic             bus_oe,
    output logic             ready
);
    logic tx_sel, rx_sel, tx_load, rx_load;

    hdx_mode_ctl #(.WAKE_CYC(WAKE_CYC)) u_ctl (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
        .tx_sel(tx_sel), .rx_sel(rx_sel),
        .tx_load(tx_load), .rx_load(rx_load), .ready(ready)
    );

    hdx_dac_path #(.DAC_W(DAC_W)) u_dac (
        .clk(clk), .rst_n(rst_n), .cap_en(tx_sel), .load(tx_load),
        .din(bus_in), .code(dac_code)
    );

    hdx_adc_path #(.ADC_W(ADC_W)) u_adc (
        .clk(clk), .rst_n(rst_n), .samp_en(rx_sel), .load(rx_load),
        .sample(adc_code), .dout(bus_out)
    );

    assign bus_oe = rx_load;

    p_oe_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (ready && rx_en && !tx_en));

endmodule

// File: tb/sim_hdx_conv_if.sv
`timescale 1ns/1ps
module sim_hdx_conv_if;
    localparam int W = 12;
    localparam int K_RDY = 0, K_DAC = 1, K_BUS = 2, K_OE = 3;

    logic clk = 1'b0;
    logic rst_n, rx_en, tx_en;
    logic [6:0] bus_in;
    logic [4:0] adc_code;
    logic [6:0] dac_code;
    logic [4:0] bus_out;
    logic bus_oe, ready;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int         due_q[$];
    int         kind_q[$];
    logic [6:0] val_q[$];
    string      tag_q[$];

    hdx_conv_if #(.WAKE_CYC(W)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
        .bus_in(bus_in), .adc_code(adc_code), .dac_code(dac_code),
        .bus_out(bus_out), .bus_oe(bus_oe), .ready(ready)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_at(input int dly, input int kind, input logic [6:0] v, input string tag);
        due_q.push_back(cyc + dly);
        kind_q.push_back(kind);
        val_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    function automatic logic [6:0] observe(input int kind);
        case (kind)
            K_RDY:   return {6'd0, ready};
            K_DAC:   return dac_code;
            K_BUS:   return {2'd0, bus_out};
            default: return {6'd0, bus_oe};
        endcase
    endfunction

    function automatic string kname(input int kind);
        case (kind)
            K_RDY:   return "ready";
            K_DAC:   return "dac_code";
            K_BUS:   return "bus_out";
            default: return "bus_oe";
        endcase
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            #5;
            for (int i = due_q.size() - 1; i >= 0; i--) begin
                if (due_q[i] == cyc) begin
                    logic [6:0] act;
                    act = observe(kind_q[i]);
                    n_run++;
                    if (act !== val_q[i]) begin
                        n_fail++;
                        $display("FAIL %s %s cycle %0d: actual %h expected %h",
                                 tag_q[i], kname(kind_q[i]), cyc, act, val_q[i]);
                    end
                    due_q.delete(i); kind_q.delete(i); val_q.delete(i); tag_q.delete(i);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_en = 1'b0; tx_en = 1'b0; bus_in = '0; adc_code = '0;
        step(3);
        // R2: reset state
        expect_at(0, K_RDY, 7'h00, "R2"); expect_at(0, K_DAC, 7'h00, "R2");
        expect_at(0, K_BUS, 7'h00, "R2"); expect_at(0, K_OE, 7'h00, "R2");
        step(1);
        rst_n = 1'b1;
        step(2);

        // R1: both enables high is shutdown
        rx_en = 1'b1; tx_en = 1'b1;
        step(W + 3);
        expect_at(0, K_RDY, 7'h00, "R1"); expect_at(0, K_OE, 7'h00, "R1");
        step(1);

        // R3: aborted wake-up restarts the count
        rx_en = 1'b0; tx_en = 1'b1;
        step(W / 2);
        tx_en = 1'b0;
        step(1);
        expect_at(0, K_RDY, 7'h00, "R3");
        tx_en = 1'b1; bus_in = 7'h11;
        expect_at(1, K_DAC, 7'h00, "R6");
        expect_at(W, K_RDY, 7'h00, "R3");
        expect_at(W + 1, K_RDY, 7'h01, "R3");
        step(W + 1);

        // R5/R9: transmit path, falling capture and rising update
        bus_in = 7'h3F; adc_code = 5'h0A;
        expect_at(1, K_DAC, 7'h3F, "R9"); expect_at(0, K_OE, 7'h00, "R8");
        expect_at(1, K_BUS, 7'h00, "R7");
        step(1);
        bus_in = 7'h40; expect_at(1, K_DAC, 7'h40, "R9");
        step(1);
        bus_in = 7'h15;
        expect_at(1, K_DAC, 7'h15, "R5");
        expect_at(2, K_DAC, 7'h2A, "R5");
        #10 bus_in = 7'h2A;
        step(2);
        bus_in = 7'h00; expect_at(1, K_DAC, 7'h00, "R9");
        step(1);

        // R4: direct switch to receive
        bus_in = 7'h33; rx_en = 1'b1; tx_en = 1'b0;
        expect_at(0, K_OE, 7'h00, "R8"); expect_at(1, K_OE, 7'h01, "R8");
        expect_at(1, K_RDY, 7'h01, "R4"); expect_at(1, K_DAC, 7'h00, "R6");
        step(1);
        adc_code = 5'h0F; bus_in = 7'h7F;
        expect_at(1, K_BUS, 7'h0F, "R9"); expect_at(1, K_DAC, 7'h00, "R6");
        step(1);
        adc_code = 5'h10; expect_at(1, K_BUS, 7'h10, "R9");
        step(1);
        adc_code = 5'h01; expect_at(1, K_BUS, 7'h01, "R7");
        step(1);

        // R8/R1: leave receive for shutdown
        rx_en = 1'b0;
        expect_at(0, K_OE, 7'h00, "R8"); expect_at(1, K_RDY, 7'h00, "R1");
        expect_at(1, K_BUS, 7'h00, "R7");
        step(2);

        // R4: receive then direct switch to transmit
        rx_en = 1'b1;
        expect_at(W + 1, K_RDY, 7'h01, "R3");
        step(W + 1);
        rx_en = 1'b0; tx_en = 1'b1; bus_in = 7'h22;
        expect_at(0, K_OE, 7'h00, "R8");
        expect_at(1, K_RDY, 7'h01, "R4"); expect_at(1, K_DAC, 7'h00, "R6");
        expect_at(2, K_DAC, 7'h22, "R4");
        step(3);

        // R2: reset while active
        rst_n = 1'b0;
        expect_at(1, K_RDY, 7'h00, "R2"); expect_at(1, K_DAC, 7'h00, "R2");
        step(1);
        rst_n = 1'b1; tx_en = 1'b0;
        step(3);

        if (due_q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL pending: actual %0d unchecked expected 0", due_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule